// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block works out the column address for every beat of an SDRAM-style read or write burst. A small mode register sets the burst length and the beat ordering. When a burst start is sampled, the block captures a 9-bit starting column. From the next cycle it presents one column address per clock, with a valid strobe. It raises a last-beat flag on the final beat of a fixed-length burst.

For fixed lengths, every beat stays inside an aligned block of columns whose size equals the burst length. The starting column's upper bits select the block, and its low bits give the first position inside it.

- In sequential order, the low bits count upward and wrap at the block edge.
- In interleaved order, the low bits are the start bits XOR the beat index.
- In continuous page mode, the block counts upward through all 512 columns without end, until a terminate or a new start.

A command sequencer drives the start and terminate inputs. It forwards the column address to the DRAM command bus.

Top module: `sdram_colseq`

## Requirements
- R1: After reset, col_valid, col_last and mode_err are 0, and the mode register holds 4'b0000 (length 1, sequential).
- R2: A cycle with mode_wr=1 loads mode_in into the mode register. Bits [2:0] set the length: 000=1, 001=2, 010=4, 011=8, 111=continuous page. Bit 3 sets the order: 0=sequential, 1=interleaved.
- R3: The length codes 100, 101 and 110 are reserved. The code 111 combined with interleaved order is also reserved. Either case sets mode_err to 1 from the cycle after the write. A start sampled while mode_err=1 produces no beat, and col_valid stays 0.
- R4: For a start sampled at clock edge N, beat 0 appears after edge N and equals start_col. Beat k appears after edge N+k. col_valid stays 1 for exactly BL consecutive cycles of a fixed-length burst.
- R5: In sequential order with fixed length BL, beat k has low log2(BL) bits equal to (start low bits + k) mod BL. Its upper bits equal those of start_col.
- R6: In interleaved order, beat k has low log2(BL) bits equal to (start low bits XOR k). Its upper bits equal those of start_col.
- R7: col_last is 1 on the final beat of a fixed-length burst and only there. In the cycle after that beat, col_valid is 0 unless a new start was sampled.
- R8: In continuous page mode, beat k equals (start_col + k) mod 512, so column 511 is followed by column 0. col_last is never asserted, and the burst runs until terminated or restarted.
- R9: A terminate sampled with no start ends the burst, and col_valid is 0 in the following cycle.
- R10: A start sampled during a burst abandons that burst. The next cycle shows beat 0 of the new burst.
- R11: A mode write during a burst leaves that burst's length and order unchanged. The new mode takes effect at the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_wr | input | 1 | Load mode_in into the mode register |
| mode_in | input | 4 | Mode value: [2:0] length code, [3] order |
| start | input | 1 | Begin a burst at start_col |
| start_col | input | 9 | Starting column address |
| term | input | 1 | End the burst in progress |
| col_out | output | 9 | Column address of the current beat |
| col_valid | output | 1 | col_out holds a beat |
| col_last | output | 1 | Current beat is the final one of a fixed burst |
| mode_err | output | 1 | Mode register holds a reserved setting |

## Verification
Every output comes straight from registers that are loaded on the clock edge that samples a control input.

- A mode write shows on mode_err one edge later.
- Beat k of a burst started at edge N is due just after edge N+k.
- The effect of a terminate, a restart or the end of a fixed burst shows one edge after it is sampled.

The bench changes inputs 1 ns after a rising edge and samples the outputs at that same offset after each following edge. Each check therefore reads exactly the beat that its edge count predicts. The expected addresses come from the modular-sum and XOR rules in the requirements.

// File: rtl/colseq_pkg.sv
package colseq_pkg;

   // width of the log2(burst length) field for fixed bursts (max length 8)
   localparam int LEN_LOG_W = 2;
   localparam int MODE_W    = 4;

   localparam logic [2:0] LCODE_1    = 3'b000;
   localparam logic [2:0] LCODE_2    = 3'b001;
   localparam logic [2:0] LCODE_4    = 3'b010;
   localparam logic [2:0] LCODE_8    = 3'b011;
   localparam logic [2:0] LCODE_PAGE = 3'b111;

   typedef struct packed {
      logic [LEN_LOG_W-1:0] len_log2;
      logic                 page;
      logic                 intlv;
      logic                 bad;
   } burst_cfg_t;

   function automatic burst_cfg_t decode_mode(input logic [MODE_W-1:0] m);
      burst_cfg_t c;
      c.len_log2 = '0;
      c.page     = 1'b0;
      c.intlv    = m[3];
      c.bad      = 1'b0;
      unique case (m[2:0])
         LCODE_1:    c.len_log2 = 2'd0;
         LCODE_2:    c.len_log2 = 2'd1;
         LCODE_4:    c.len_log2 = 2'd2;
         LCODE_8:    c.len_log2 = 2'd3;
         LCODE_PAGE: begin
            c.page = 1'b1;
            c.bad  = m[3];
         end
         default:    c.bad = 1'b1;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/colseq_mode_reg.sv
module colseq_mode_reg
   import colseq_pkg::*;
#(
   parameter int MW = MODE_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [MW-1:0] mode_in,
   output burst_cfg_t    cfg
);

   if (MW != MODE_W) begin : g_bad_mw
      $error("colseq_mode_reg: MW must equal the package mode width");
   end

   logic [MW-1:0] mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mode_q <= '0;
      else if (wr) mode_q <= mode_in;
   end

   always_comb cfg = decode_mode(mode_q);

   // R3: reserved setting flagged the cycle after it is written
   p_err_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (cfg.bad == (((mode_q[2:0] == 3'b100) || (mode_q[2:0] == 3'b101) ||
                           (mode_q[2:0] == 3'b110)) ||
                          ((mode_q[2:0] == 3'b111) && mode_q[3]))));

   // R11: register only changes when written
   p_mode_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(mode_q));

endmodule

// File: rtl/colseq_addr_calc.sv
module colseq_addr_calc
   import colseq_pkg::*;
#(
   parameter int COL_W    = 9,
   parameter bit INTLV_EN = 1'b1
) (
   input  logic [COL_W-1:0]     base,
   input  logic [COL_W-1:0]     beat,
   input  logic [LEN_LOG_W-1:0] len_log2,
   input  logic                 page,
   input  logic                 intlv,
   output logic [COL_W-1:0]     col
);

   localparam int MAX_LOG = (1 << LEN_LOG_W) - 1;

   if (COL_W <= MAX_LOG) begin : g_bad_w
      $error("colseq_addr_calc: COL_W must exceed the largest fixed block");
   end

   logic [COL_W-1:0] sum_w;
   logic [COL_W-1:0] xor_w;

   always_comb sum_w = base + beat;

   if (INTLV_EN) begin : g_xor
      always_comb xor_w = base ^ beat;
   end else begin : g_no_xor
      always_comb xor_w = sum_w;
   end

   // per bit: inside the burst block take the ordered value, else hold base
   for (genvar i = 0; i < COL_W; i++) begin : g_bit
      logic in_blk;
      if (i < MAX_LOG) begin : g_low
         always_comb in_blk = page || (LEN_LOG_W'(i) < len_log2);
      end else begin : g_high
         always_comb in_blk = page;
      end
      always_comb col[i] = in_blk ? ((intlv && !page) ? xor_w[i] : sum_w[i]) : base[i];
   end

endmodule

// File: rtl/colseq_beat_ctl.sv
module colseq_beat_ctl
   import colseq_pkg::*;
#(
   parameter int COL_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [COL_W-1:0] start_col,
   input  logic             term,
   input  burst_cfg_t       cfg,
   output logic             run,
   output logic [COL_W-1:0] beat,
   output logic [COL_W-1:0] base,
   output burst_cfg_t       cfg_q,
   output logic             fin
);

   logic [COL_W-1:0] run_q_beat;
   logic             run_q;
   logic [COL_W-1:0] base_q;
   burst_cfg_t       cfg_r;
   logic [COL_W-1:0] final_beat;

   always_comb final_beat = COL_W'((1 << cfg_r.len_log2) - 1);
   always_comb fin = run_q && !cfg_r.page && (run_q_beat == final_beat);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q      <= 1'b0;
         run_q_beat <= '0;
         base_q     <= '0;
         cfg_r      <= '0;
      end else if (start) begin
         run_q      <= !cfg.bad;
         run_q_beat <= '0;
         base_q     <= start_col;
         cfg_r      <= cfg;
      end else if (term) begin
         run_q <= 1'b0;
      end else if (run_q) begin
         if (fin) run_q <= 1'b0;
         else     run_q_beat <= run_q_beat + 1'b1;
      end
   end

   always_comb begin
      run   = run_q;
      beat  = run_q_beat;
      base  = base_q;
      cfg_q = cfg_r;
   end

   // R3: a start with a reserved mode does not launch a burst
   p_no_burst_bad_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (start && cfg.bad) |=> !run_q);

   // R9: terminate without start stops the burst
   p_term_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (term && !start) |=> !run_q);

   // R11: captured settings stay fixed through a burst
   p_cfg_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !start) |=> $stable(cfg_r));

endmodule

// File: rtl/sdram_colseq.sv
module sdram_colseq
   import colseq_pkg::*;
#(
   parameter int COL_W    = 9,
   parameter bit INTLV_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_wr,
   input  logic [3:0]       mode_in,
   input  logic             start,
   input  logic [COL_W-1:0] start_col,
   input  logic             term,
   output logic [COL_W-1:0] col_out,
   output logic             col_valid,
   output logic             col_last,
   output logic             mode_err
);

   localparam int BLK_MAX_LOG = (1 << LEN_LOG_W) - 1;

   burst_cfg_t       cfg_w;
   burst_cfg_t       cfg_run;
   logic             run_w;
   logic             fin_w;
   logic [COL_W-1:0] beat_w;
   logic [COL_W-1:0] base_w;
   logic [COL_W-1:0] col_w;

   colseq_mode_reg #(.MW(MODE_W)) i_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (mode_wr),
      .mode_in (mode_in),
      .cfg     (cfg_w)
   );

   colseq_beat_ctl #(.COL_W(COL_W)) i_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .start_col (start_col),
      .term      (term),
      .cfg       (cfg_w),
      .run       (run_w),
      .beat      (beat_w),
      .base      (base_w),
      .cfg_q     (cfg_run),
      .fin       (fin_w)
   );

   colseq_addr_calc #(.COL_W(COL_W), .INTLV_EN(INTLV_EN)) i_addr (
      .base     (base_w),
      .beat     (beat_w),
      .len_log2 (cfg_run.len_log2),
      .page     (cfg_run.page),
      .intlv    (cfg_run.intlv),
      .col      (col_w)
   );

   always_comb begin
      col_out   = col_w;
      col_valid = run_w;
      col_last  = fin_w;
      mode_err  = cfg_w.bad;
   end

   // R4: beat 0 is the start column, one edge after a good start
   p_beat0_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !cfg_w.bad) |=> (col_valid && (col_out == $past(start_col))));

   // R5/R6: fixed bursts never leave their aligned block
   p_in_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (col_valid && !start && !term && !col_last && !cfg_run.page) |=>
         (col_out[COL_W-1:BLK_MAX_LOG] == $past(col_out[COL_W-1:BLK_MAX_LOG])));

   // R7: last implies valid, and the burst closes after it
   p_last_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      col_last |-> col_valid);
   p_end_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (col_last && !start) |=> !col_valid);

   // R8: continuous page bursts advance by one and never flag last
   p_page_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (col_valid && cfg_run.page && !start && !term) |=>
         (col_valid && (col_out == COL_W'($past(col_out) + 1'b1)) && !col_last));

endmodule

// File: tb/test_sdram_colseq.sv
`timescale 1ns/1ps
module test_sdram_colseq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_wr = 1'b0;
   logic [3:0] mode_in = '0;
   logic       start = 1'b0;
   logic [8:0] start_col = '0;
   logic       term = 1'b0;
   logic [8:0] col_out;
   logic       col_valid;
   logic       col_last;
   logic       mode_err;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   sdram_colseq i_sdram_colseq (
      .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_in(mode_in),
      .start(start), .start_col(start_col), .term(term),
      .col_out(col_out), .col_valid(col_valid), .col_last(col_last),
      .mode_err(mode_err)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   // bl = 0 means continuous page
   function automatic logic [8:0] exp_col(input logic [8:0] s, input int k,
                                          input int bl, input bit il);
      logic [8:0] m;
      logic [8:0] lo;
      if (bl == 0) return 9'(s + 9'(k));
      m  = 9'(bl - 1);
      lo = il ? ((s & m) ^ 9'(k)) : (9'(s + 9'(k)) & m);
      return (s & ~m) | (lo & m);
   endfunction

   task automatic wr_mode(input logic [3:0] m);
      mode_wr = 1'b1;
      mode_in = m;
      tick();
      mode_wr = 1'b0;
   endtask

   // one complete fixed burst, all beats checked, then the idle cycle
   task automatic run_fixed(input logic [8:0] s, input int bl, input bit il, input string req);
      start     = 1'b1;
      start_col = s;
      for (int k = 0; k < bl; k++) begin
         tick();
         start = 1'b0;
         chk(col_valid === 1'b1, {req, " valid"}, int'(col_valid), 1);
         chk(col_out === exp_col(s, k, bl, il), {req, " col"}, int'(col_out),
             int'(exp_col(s, k, bl, il)));
         chk(col_last === (k == bl - 1), "R7 last flag", int'(col_last), int'(k == bl - 1));
      end
      tick();
      chk(col_valid === 1'b0, "R7 idle after last", int'(col_valid), 0);
   endtask

   task automatic t_reset();
      tick();
      chk(col_valid === 1'b0, "R1 valid", int'(col_valid), 0);
      chk(col_last === 1'b0, "R1 last", int'(col_last), 0);
      chk(mode_err === 1'b0, "R1 err", int'(mode_err), 0);
      rst_n = 1'b1;
      tick();
      // reset mode is length 1 sequential
      run_fixed(9'd77, 1, 1'b0, "R1 default mode");
   endtask

   task automatic t_sequential();
      wr_mode(4'b0001); run_fixed(9'd301, 2, 1'b0, "R5 seq BL2");
      wr_mode(4'b0010); run_fixed(9'd6,   4, 1'b0, "R5 seq BL4");
      wr_mode(4'b0011); run_fixed(9'd109, 8, 1'b0, "R5 seq BL8");
      wr_mode(4'b0011); run_fixed(9'd511, 8, 1'b0, "R4 seq BL8 top");
   endtask

   task automatic t_interleaved();
      wr_mode(4'b1001); run_fixed(9'd33,  2, 1'b1, "R6 il BL2");
      wr_mode(4'b1010); run_fixed(9'd202, 4, 1'b1, "R6 il BL4");
      wr_mode(4'b1011); run_fixed(9'd13,  8, 1'b1, "R6 il BL8");
      wr_mode(4'b1000); run_fixed(9'd5,   1, 1'b1, "R2 il BL1");
   endtask

   task automatic t_page_term();
      wr_mode(4'b0111);
      chk(mode_err === 1'b0, "R2 page legal", int'(mode_err), 0);
      start = 1'b1; start_col = 9'd508;
      for (int k = 0; k < 7; k++) begin
         tick();
         start = 1'b0;
         chk(col_out === exp_col(9'd508, k, 0, 1'b0), "R8 page col", int'(col_out),
             int'(exp_col(9'd508, k, 0, 1'b0)));
         chk(col_valid === 1'b1 && col_last === 1'b0, "R8 page valid no last",
             int'({col_valid, col_last}), 2);
      end
      term = 1'b1;
      tick();
      term = 1'b0;
      chk(col_valid === 1'b0, "R9 term", int'(col_valid), 0);
      // terminate partway through a fixed burst
      wr_mode(4'b0011);
      start = 1'b1; start_col = 9'd40;
      tick(); start = 1'b0;
      tick();
      chk(col_out === 9'd41, "R9 before term", int'(col_out), 41);
      term = 1'b1;
      tick();
      term = 1'b0;
      chk(col_valid === 1'b0, "R9 fixed term", int'(col_valid), 0);
   endtask

   task automatic t_reserved();
      logic [3:0] bad_modes [4] = '{4'b0100, 4'b0101, 4'b0110, 4'b1111};
      for (int i = 0; i < 4; i++) begin
         wr_mode(bad_modes[i]);
         chk(mode_err === 1'b1, "R3 err flag", int'(mode_err), 1);
         start = 1'b1; start_col = 9'd3;
         tick(); start = 1'b0;
         chk(col_valid === 1'b0, "R3 no burst", int'(col_valid), 0);
         tick();
         chk(col_valid === 1'b0, "R3 still idle", int'(col_valid), 0);
      end
      wr_mode(4'b0010);
      chk(mode_err === 1'b0, "R3 err clears", int'(mode_err), 0);
   endtask

   task automatic t_restart_and_mode_change();
      wr_mode(4'b0011);
      start = 1'b1; start_col = 9'd100;
      tick(); start = 1'b0;
      tick();
      chk(col_out === 9'd101, "R10 first burst", int'(col_out), 101);
      start = 1'b1; start_col = 9'd250;
      tick(); start = 1'b0;
      chk(col_out === 9'd250 && col_valid === 1'b1, "R10 restart beat0", int'(col_out), 250);
      // mode write mid burst: still 8 beats sequential from 250
      mode_wr = 1'b1; mode_in = 4'b1001;
      for (int k = 1; k < 8; k++) begin
         tick();
         mode_wr = 1'b0;
         chk(col_out === exp_col(9'd250, k, 8, 1'b0), "R11 burst unchanged",
             int'(col_out), int'(exp_col(9'd250, k, 8, 1'b0)));
      end
      chk(col_last === 1'b1, "R11 last at 8", int'(col_last), 1);
      tick();
      chk(col_valid === 1'b0, "R11 end", int'(col_valid), 0);
      run_fixed(9'd250, 2, 1'b1, "R11 new mode used");
   endtask

   initial begin
      t_reset();
      t_sequential();
      t_interleaved();
      t_page_term();
      t_reserved();
      t_restart_and_mode_change();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule